// File: doc/BRIEF.md
# Home-Node Directory Coherence Controller

This block is the home-node directory for the memory blocks held at one node of a distributed-memory multiprocessor. Requesting processors send it read misses, write misses and write-backs. For every block it owns, it keeps a directory entry made of a three-state code and a presence vector with one bit per processor. It answers each request with messages toward the processors: data replies, invalidations, and fetches that pull a dirty copy back from its owner. It also holds the data of its own blocks, so it can answer a miss and absorb a write-back without any outside memory.

Requests are handled strictly one at a time. The controller accepts a request, looks up the entry of the addressed block and updates it. It then sends the messages the transaction needs, at most one per cycle, and takes the next request only when the last message has gone out. When a fetch is outstanding, the owner answers on a separate fetch-response input. The controller writes the returned data into the block before it forwards that data to the requester.

Top module: `dir_ctrl`

## Requirements
- R1: After reset, `req_ready_o` is 1 and `msg_valid_o` is 0. Every directory entry is uncached with an empty vector, and every block holds zero.
- R2: A read miss (`req_type_i` = 0) to a block that is uncached or shared sends one data reply (`msg_type_o` = 0) to the requester carrying the block's data. It adds the requester to the vector and leaves the block shared. The entries of other blocks do not change.
- R3: A write miss (`req_type_i` = 1) to a shared block sends one invalidation (`msg_type_o` = 1) to each sharer other than the requester. They go out one per cycle, lowest processor index first, and are followed by a data reply to the requester. Afterwards the requester is the only vector bit and the block is exclusive.
- R4: A write miss to an uncached block, or to a shared block whose only sharer is the requester, sends only the data reply. The requester becomes the exclusive holder.
- R5: A read miss to an exclusive block sends a fetch (`msg_type_o` = 2) to the owner. The controller waits for `fetch_valid_i`, stores `fetch_data_i` in the block and replies to the requester with that data. Afterwards owner and requester are sharers and the block is shared.
- R6: A write miss to an exclusive block sends a fetch-and-invalidate (`msg_type_o` = 3) to the owner. The controller stores the returned data and replies with it. Afterwards the requester is the sole exclusive holder.
- R7: A write-back (`req_type_i` = 2) from the owner of an exclusive block stores `req_data_i` in the block, clears the vector and makes the block uncached. It sends no message.
- R8: A write-back from any processor that is not the exclusive owner of the block changes neither data nor directory, and sends no message.
- R9: `req_ready_o` is low from the cycle after a request is accepted until the transaction's last message has been sent, and no message is sent while it is high. A data reply always ends a transaction.
- R10: Consecutive invalidations within one transaction go to strictly increasing processor indices. A fetch is never directly followed by another message in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Controller can accept a request |
| req_type_i | input | 2 | 0 read miss, 1 write miss, 2 write-back |
| req_src_i | input | ID_W | Requesting processor |
| req_addr_i | input | BA_W | Block index within this home node |
| req_data_i | input | DATA_W | Write-back data |
| fetch_valid_i | input | 1 | Owner's answer to a fetch is present |
| fetch_data_i | input | DATA_W | Data returned by the owner |
| msg_valid_o | output | 1 | Outgoing message present |
| msg_type_o | output | 2 | 0 data, 1 invalidate, 2 fetch, 3 fetch-and-invalidate |
| msg_dst_o | output | ID_W | Destination processor |
| msg_addr_o | output | BA_W | Block the message concerns |
| msg_data_o | output | DATA_W | Reply data (zero for other types) |

## Verification
One block is driven through its whole life cycle. Three readers build up a sharer set, which a write miss then breaks. The exact list and order of the invalidations shows whether the vector held every sharer and whether the requester was left out. A read and then a write aimed at an exclusive block tell the fetch flavours apart. Each reply must carry the owner's returned data, not the stale stored value. Write-backs from a non-owner and then from the owner are followed by a write miss: its data shows which write-back was stored, and the absence of invalidations shows that the vector was cleared. Further blocks, including the highest index and a block whose only sharer upgrades, check that entries stay independent and that the upgrade needs no invalidation.

// File: rtl/dir_pkg.sv
package dir_pkg;
  typedef enum logic [1:0] {REQ_RD = 2'd0, REQ_WR = 2'd1, REQ_WB = 2'd2} req_e;
  typedef enum logic [1:0] {MSG_DATA = 2'd0, MSG_INV = 2'd1, MSG_FETCH = 2'd2, MSG_FETCH_INV = 2'd3} msg_e;
  typedef enum logic [1:0] {D_UNC = 2'd0, D_SHR = 2'd1, D_EXC = 2'd2} dstate_e;
  typedef enum logic [2:0] {S_IDLE, S_DEC, S_INV, S_FETCH, S_WAIT, S_REPLY} fsm_e;
endpackage

// File: rtl/dir_store.sv
module dir_store
  import dir_pkg::*;
#(
  parameter int N_PROC = 4,
  parameter int N_BLK  = 16,
  localparam int BA_W = $clog2(N_BLK)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BA_W-1:0]   addr_i,
  output dstate_e           rd_state_o,
  output logic [N_PROC-1:0] rd_vec_o,
  input  logic              we_i,
  input  dstate_e           wr_state_i,
  input  logic [N_PROC-1:0] wr_vec_i
);
  dstate_e           st_q  [N_BLK];
  logic [N_PROC-1:0] vec_q [N_BLK];

  for (genvar b = 0; b < N_BLK; b++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        st_q[b]  <= D_UNC;
        vec_q[b] <= '0;
      end else if (we_i && addr_i == BA_W'(b)) begin
        st_q[b]  <= wr_state_i;
        vec_q[b] <= wr_vec_i;
      end
    end
  end

  assign rd_state_o = st_q[addr_i];
  assign rd_vec_o   = vec_q[addr_i];
endmodule

// File: rtl/dir_mem.sv
module dir_mem #(
  parameter int N_BLK  = 16,
  parameter int DATA_W = 32,
  localparam int BA_W = $clog2(N_BLK)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BA_W-1:0]   addr_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i
);
  logic [DATA_W-1:0] mem_q [N_BLK];

  for (genvar b = 0; b < N_BLK; b++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               mem_q[b] <= '0;
      else if (we_i && addr_i == BA_W'(b))       mem_q[b] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/dir_fsm.sv
module dir_fsm
  import dir_pkg::*;
#(
  parameter int N_PROC = 4,
  parameter int N_BLK  = 16,
  parameter int DATA_W = 32,
  localparam int ID_W = $clog2(N_PROC),
  localparam int BA_W = $clog2(N_BLK)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [1:0]        req_type_i,
  input  logic [ID_W-1:0]   req_src_i,
  input  logic [BA_W-1:0]   req_addr_i,
  input  logic [DATA_W-1:0] req_data_i,
  input  logic              fetch_valid_i,
  input  logic [DATA_W-1:0] fetch_data_i,
  output logic [BA_W-1:0]   blk_o,
  input  dstate_e           dir_state_i,
  input  logic [N_PROC-1:0] dir_vec_i,
  output logic              dir_we_o,
  output dstate_e           dir_state_o,
  output logic [N_PROC-1:0] dir_vec_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              mem_we_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              msg_valid_o,
  output logic [1:0]        msg_type_o,
  output logic [ID_W-1:0]   msg_dst_o,
  output logic [DATA_W-1:0] msg_data_o
);
  fsm_e              st_q, st_d;
  req_e              type_q;
  logic [ID_W-1:0]   src_q, tgt_q, own_idx, inv_idx;
  logic [BA_W-1:0]   addr_q;
  logic [DATA_W-1:0] data_q;
  logic [N_PROC-1:0] mask_q, src_bit, others;

  always_comb begin
    src_bit = '0;
    src_bit[src_q] = 1'b1;
    others  = dir_vec_i & ~src_bit;
    own_idx = '0;
    inv_idx = '0;
    for (int i = N_PROC - 1; i >= 0; i--) begin
      if (dir_vec_i[i]) own_idx = ID_W'(i);
      if (mask_q[i])    inv_idx = ID_W'(i);
    end
  end

  always_comb begin
    st_d        = st_q;
    dir_we_o    = 1'b0;
    dir_state_o = D_UNC;
    dir_vec_o   = '0;
    mem_we_o    = 1'b0;
    mem_wdata_o = data_q;
    unique case (st_q)
      S_IDLE:  if (req_valid_i) st_d = S_DEC;
      S_DEC: begin
        st_d = S_IDLE;
        case (type_q)
          REQ_RD: begin
            dir_we_o    = 1'b1;
            dir_state_o = D_SHR;
            dir_vec_o   = dir_vec_i | src_bit;
            st_d        = (dir_state_i == D_EXC) ? S_FETCH : S_REPLY;
          end
          REQ_WR: begin
            dir_we_o    = 1'b1;
            dir_state_o = D_EXC;
            dir_vec_o   = src_bit;
            if (dir_state_i == D_EXC) st_d = S_FETCH;
            else if (|others)         st_d = S_INV;
            else                      st_d = S_REPLY;
          end
          REQ_WB: begin
            // only the recorded owner may retire the block
            if (dir_state_i == D_EXC && dir_vec_i == src_bit) begin
              dir_we_o    = 1'b1;
              dir_state_o = D_UNC;
              mem_we_o    = 1'b1;
            end
          end
          default: ;
        endcase
      end
      S_INV:   if ((mask_q & (mask_q - 1'b1)) == '0) st_d = S_REPLY;
      S_FETCH: st_d = S_WAIT;
      S_WAIT: begin
        if (fetch_valid_i) begin
          mem_we_o    = 1'b1;
          mem_wdata_o = fetch_data_i;
          st_d        = S_REPLY;
        end
      end
      S_REPLY: st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      type_q <= REQ_RD;
      src_q  <= '0;
      addr_q <= '0;
      data_q <= '0;
      mask_q <= '0;
      tgt_q  <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == S_IDLE && req_valid_i) begin
        type_q <= req_e'(req_type_i);
        src_q  <= req_src_i;
        addr_q <= req_addr_i;
        data_q <= req_data_i;
      end
      if (st_q == S_DEC) begin
        mask_q <= others;
        tgt_q  <= own_idx;
      end else if (st_q == S_INV) begin
        mask_q <= mask_q & (mask_q - 1'b1);
      end
    end
  end

  assign req_ready_o = (st_q == S_IDLE);
  assign blk_o       = addr_q;
  assign msg_valid_o = (st_q == S_INV) || (st_q == S_FETCH) || (st_q == S_REPLY);

  always_comb begin
    msg_type_o = MSG_DATA;
    msg_dst_o  = src_q;
    msg_data_o = '0;
    case (st_q)
      S_INV: begin
        msg_type_o = MSG_INV;
        msg_dst_o  = inv_idx;
      end
      S_FETCH: begin
        msg_type_o = (type_q == REQ_WR) ? MSG_FETCH_INV : MSG_FETCH;
        msg_dst_o  = tgt_q;
      end
      S_REPLY: msg_data_o = mem_rdata_i;
      default: ;
    endcase
  end
endmodule

// File: rtl/dir_ctrl.sv
module dir_ctrl
  import dir_pkg::*;
#(
  parameter int N_PROC = 4,
  parameter int N_BLK  = 16,
  parameter int DATA_W = 32,
  localparam int ID_W = $clog2(N_PROC),
  localparam int BA_W = $clog2(N_BLK)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [1:0]        req_type_i,
  input  logic [ID_W-1:0]   req_src_i,
  input  logic [BA_W-1:0]   req_addr_i,
  input  logic [DATA_W-1:0] req_data_i,
  input  logic              fetch_valid_i,
  input  logic [DATA_W-1:0] fetch_data_i,
  output logic              msg_valid_o,
  output logic [1:0]        msg_type_o,
  output logic [ID_W-1:0]   msg_dst_o,
  output logic [BA_W-1:0]   msg_addr_o,
  output logic [DATA_W-1:0] msg_data_o
);
  logic [BA_W-1:0]   blk;
  dstate_e           rd_state, wr_state;
  logic [N_PROC-1:0] rd_vec, wr_vec;
  logic              dir_we, mem_we;
  logic [DATA_W-1:0] mem_rdata, mem_wdata;

  dir_store #(.N_PROC(N_PROC), .N_BLK(N_BLK)) u_store (
    .clk_i, .rst_ni, .addr_i(blk),
    .rd_state_o(rd_state), .rd_vec_o(rd_vec),
    .we_i(dir_we), .wr_state_i(wr_state), .wr_vec_i(wr_vec)
  );

  dir_mem #(.N_BLK(N_BLK), .DATA_W(DATA_W)) u_mem (
    .clk_i, .rst_ni, .addr_i(blk), .rdata_o(mem_rdata),
    .we_i(mem_we), .wdata_i(mem_wdata)
  );

  dir_fsm #(.N_PROC(N_PROC), .N_BLK(N_BLK), .DATA_W(DATA_W)) u_fsm (
    .clk_i, .rst_ni,
    .req_valid_i, .req_ready_o, .req_type_i, .req_src_i, .req_addr_i, .req_data_i,
    .fetch_valid_i, .fetch_data_i,
    .blk_o(blk), .dir_state_i(rd_state), .dir_vec_i(rd_vec),
    .dir_we_o(dir_we), .dir_state_o(wr_state), .dir_vec_o(wr_vec),
    .mem_rdata_i(mem_rdata), .mem_we_o(mem_we), .mem_wdata_o(mem_wdata),
    .msg_valid_o, .msg_type_o, .msg_dst_o, .msg_data_o
  );

  assign msg_addr_o = blk;
endmodule

// File: rtl/dir_ctrl_chk.sv
module dir_ctrl_chk #(
  parameter int ID_W = 2
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            req_valid_i,
  input logic            req_ready_o,
  input logic            msg_valid_o,
  input logic [1:0]      msg_type_o,
  input logic [ID_W-1:0] msg_dst_o
);
  p_busy_after_accept_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);

  p_no_msg_when_ready_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o |-> !req_ready_o);

  p_reply_ends_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_valid_o && msg_type_o == 2'd0) |=> req_ready_o);

  p_inv_followed_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_valid_o && msg_type_o == 2'd1) |=> msg_valid_o && (msg_type_o inside {2'd0, 2'd1}));

  p_inv_order_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_valid_o && msg_type_o == 2'd1 && $past(msg_valid_o) && $past(msg_type_o) == 2'd1)
      |-> msg_dst_o > $past(msg_dst_o));

  p_fetch_gap_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_valid_o && msg_type_o[1]) |=> !msg_valid_o && !req_ready_o);
endmodule

bind dir_ctrl dir_ctrl_chk #(.ID_W(ID_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
  .msg_valid_o(msg_valid_o), .msg_type_o(msg_type_o), .msg_dst_o(msg_dst_o)
);

// File: tb/sim_dir_ctrl.sv
`timescale 1ns/1ps
module sim_dir_ctrl;
  localparam int N_PROC = 4, N_BLK = 16, DATA_W = 32;
  localparam int ID_W = $clog2(N_PROC), BA_W = $clog2(N_BLK);

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, fetch_valid = 1'b0;
  logic req_ready, msg_valid;
  logic [1:0] req_type = '0, msg_type;
  logic [ID_W-1:0] req_src = '0, msg_dst;
  logic [BA_W-1:0] req_addr = '0, msg_addr;
  logic [DATA_W-1:0] req_data = '0, fetch_data = '0, msg_data;
  logic [DATA_W-1:0] owner_data = '0;

  typedef struct {
    logic [1:0] t; logic [ID_W-1:0] d; logic [BA_W-1:0] a; logic [DATA_W-1:0] v; string tag;
  } exp_t;
  exp_t q[$];
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  dir_ctrl #(.N_PROC(N_PROC), .N_BLK(N_BLK), .DATA_W(DATA_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_type_i(req_type),
    .req_src_i(req_src), .req_addr_i(req_addr), .req_data_i(req_data),
    .fetch_valid_i(fetch_valid), .fetch_data_i(fetch_data),
    .msg_valid_o(msg_valid), .msg_type_o(msg_type), .msg_dst_o(msg_dst),
    .msg_addr_o(msg_addr), .msg_data_o(msg_data)
  );

  task automatic check(input bit ok, input string tag, input string act, input string exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %s expected %s", tag, act, exp);
    end
  endtask

  task automatic expect_msg(input logic [1:0] t, input int d, input int a, input logic [DATA_W-1:0] v,
                            input string tag);
    exp_t e;
    e.t = t; e.d = ID_W'(d); e.a = BA_W'(a); e.v = v; e.tag = tag;
    q.push_back(e);
  endtask

  // encodings: req 0 rd / 1 wr / 2 wb; msg 0 data / 1 inv / 2 fetch / 3 fetch-inv
  task automatic issue(input logic [1:0] t, input int src, input int a, input logic [DATA_W-1:0] v,
                       input string tag);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_type = t; req_src = ID_W'(src); req_addr = BA_W'(a); req_data = v;
    @(negedge clk);
    req_valid = 1'b0;
    while (!req_ready) @(negedge clk);
    check(q.size() == 0, tag, $sformatf("%0d outstanding", q.size()), "0 outstanding");
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && msg_valid) begin
      if (q.size() == 0) begin
        check(1'b0, "R9", $sformatf("type %0d dst %0d", msg_type, msg_dst), "no message");
      end else begin
        exp_t e;
        e = q.pop_front();
        check(msg_type == e.t && msg_dst == e.d && msg_addr == e.a && msg_data == e.v, e.tag,
              $sformatf("t%0d d%0d a%0d v%h", msg_type, msg_dst, msg_addr, msg_data),
              $sformatf("t%0d d%0d a%0d v%h", e.t, e.d, e.a, e.v));
      end
    end
  end

  // owner model answering fetches
  initial forever begin
    @(negedge clk);
    if (rst_n && msg_valid && msg_type[1]) begin
      @(negedge clk);
      fetch_valid = 1'b1; fetch_data = owner_data;
      @(negedge clk);
      fetch_valid = 1'b0;
    end
  end

  initial begin
    #(8 * 100000);
    check(1'b0, "watchdog", "hung", "done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(req_ready === 1'b1 && msg_valid === 1'b0, "R1",
          $sformatf("rdy %b vld %b", req_ready, msg_valid), "rdy 1 vld 0");
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready === 1'b1 && msg_valid === 1'b0, "R1",
          $sformatf("rdy %b vld %b", req_ready, msg_valid), "rdy 1 vld 0");

    // R1 R2: uncached block 3 reads zero, sharers build up
    expect_msg(0, 0, 3, 0, "R2"); issue(0, 0, 3, 0, "R2");
    expect_msg(0, 1, 3, 0, "R2"); issue(0, 1, 3, 0, "R2");
    expect_msg(0, 2, 3, 0, "R2"); issue(0, 2, 3, 0, "R2");
    // R3: upgrade by sharer 2 invalidates 0 then 1
    expect_msg(1, 0, 3, 0, "R3"); expect_msg(1, 1, 3, 0, "R3");
    expect_msg(0, 2, 3, 0, "R3"); issue(1, 2, 3, 0, "R3");
    // R5: read of exclusive block fetches from owner 2
    owner_data = 32'hA5A5_0003;
    expect_msg(2, 2, 3, 0, "R5"); expect_msg(0, 3, 3, 32'hA5A5_0003, "R5");
    issue(0, 3, 3, 0, "R5");
    // R3 R5: owner and reader both sharers now
    expect_msg(1, 2, 3, 0, "R3"); expect_msg(1, 3, 3, 0, "R3");
    expect_msg(0, 0, 3, 32'hA5A5_0003, "R3"); issue(1, 0, 3, 0, "R3");
    // R8: non-owner write-back ignored; R7: owner write-back stored
    issue(2, 1, 3, 32'hDEAD_BEEF, "R8");
    issue(2, 0, 3, 32'h0000_1234, "R7");
    // R4 R7 R8: uncached write miss, data from owner write-back, no invals
    expect_msg(0, 1, 3, 32'h0000_1234, "R4"); issue(1, 1, 3, 0, "R4");
    // R6: write miss to exclusive
    owner_data = 32'h5555_AAAA;
    expect_msg(3, 1, 3, 0, "R6"); expect_msg(0, 2, 3, 32'h5555_AAAA, "R6");
    issue(1, 2, 3, 0, "R6");
    // R8: write-back from non-owner to uncached-later block; R7 then clears
    issue(2, 2, 3, 32'h0000_0077, "R7");
    issue(2, 2, 3, 32'h0000_0099, "R8");
    expect_msg(0, 0, 3, 32'h0000_0077, "R8"); issue(0, 0, 3, 0, "R8");
    // R2: independent block 0
    expect_msg(0, 3, 0, 0, "R2"); issue(0, 3, 0, 0, "R2");
    expect_msg(1, 3, 0, 0, "R3"); expect_msg(0, 1, 0, 0, "R3"); issue(1, 1, 0, 0, "R3");
    // R4: highest block, and sole-sharer upgrade
    expect_msg(0, 0, 15, 0, "R4"); issue(1, 0, 15, 0, "R4");
    expect_msg(0, 3, 5, 0, "R2"); issue(0, 3, 5, 0, "R2");
    expect_msg(0, 3, 5, 0, "R4"); issue(1, 3, 5, 0, "R4");
    // R10: invalidate order with all three others sharing block 7
    expect_msg(0, 3, 7, 0, "R2"); issue(0, 3, 7, 0, "R2");
    expect_msg(0, 1, 7, 0, "R2"); issue(0, 1, 7, 0, "R2");
    expect_msg(0, 0, 7, 0, "R2"); issue(0, 0, 7, 0, "R2");
    expect_msg(1, 0, 7, 0, "R10"); expect_msg(1, 1, 7, 0, "R10"); expect_msg(1, 3, 7, 0, "R10");
    expect_msg(0, 2, 7, 0, "R10"); issue(1, 2, 7, 0, "R10");

    repeat (4) @(negedge clk);
    check(q.size() == 0 && req_ready, "R9", $sformatf("%0d left", q.size()), "0 left");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule